// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Shared-Memory Multicycle Datapath

This block steers a multicycle datapath that has one memory, one ALU and a register file. A micro-address register selects a word in a small control store. Each word packs eight narrow fields. A decoder expands these fields into the individual select and enable lines that the datapath needs. A two-bit sequencing field picks the next micro-address. It can return to the fetch word, jump through a dispatch table indexed by the instruction opcode, or step to the following word.

The control store holds microcode for five instruction classes: register-register ALU operations, OR with an immediate, load word, store word and branch-if-equal. The control lines are driven combinationally from the current word. The datapath applies them at the end of the cycle. The opcode is looked at only on the decode step. The ALU zero flag matters only where a word asks for a conditional PC write. An instruction takes 3 cycles (branch), 4 cycles (ALU, OR-immediate, store) or 5 cycles (load), counting fetch and decode.

Top module: `useq_ctrl`

## Requirements
- R1: A low `rst_n` at a clock edge sets the micro-address to 0. While reset is held, and in the first cycle after it, the outputs show the fetch word.
- R2: The fetch word drives: alu_op=00 (add), alu_sel_a=0 (PC), alu_sel_b=00 (constant 4), mem_read=1, iord=0, ir_write=1, pc_write=1, pc_source=0, pc_en=1. All other outputs are 0. The next word is the following address.
- R3: The decode word drives: alu_op=00, alu_sel_a=0, alu_sel_b=10 (shifted sign-extended offset), ext_op=1. All write and read enables are 0. The next address comes from the opcode sampled in this cycle: 000000 goes to 4, 000100 to 3, 001101 to 6, 100011 to 8 and 101011 to 11. The opcode in any other cycle has no effect.
- R4: Sequencing codes: 00 sets the next micro-address to 0, 01 takes it from the dispatch table, and 10 adds one. Every final word of an instruction uses 00.
- R5: A register-register operation runs an execute cycle with alu_op=10, alu_sel_a=1, alu_sel_b=01. It then runs a write-back cycle with the same ALU selects plus reg_write=1 and reg_dst=1 (rd from ALU).
- R6: OR-immediate runs alu_op=11, alu_sel_a=1, alu_sel_b=11, ext_op=0 (zero-extend). It then writes back with reg_write=1 and reg_dst=0.
- R7: A load runs three cycles after decode, all with alu_op=00, alu_sel_a=1, alu_sel_b=11, ext_op=1. The first is address only. The second adds mem_read=1 and iord=1. The third adds reg_write=1 and mem_to_reg=1 (rt from memory).
- R8: A store runs an address cycle like the load, then a cycle with mem_write=1 and iord=1. mem_read and mem_write are never 1 together.
- R9: A branch runs alu_op=01 (subtract), alu_sel_a=1, alu_sel_b=01, pc_write_cond=1, pc_source=1. In that cycle pc_en equals alu_zero. In every other cycle alu_zero has no effect on pc_en.
- R10: An opcode outside the five classes sends the sequencer from decode straight back to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Instruction opcode from the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| alu_op | output | 2 | ALU function: 00 add, 01 subtract, 10 function code, 11 OR |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 register rs |
| alu_sel_b | output | 2 | Second ALU operand: 00 four, 01 rt, 10 shifted immediate, 11 immediate |
| ext_op | output | 1 | Immediate extension: 1 sign, 0 zero |
| reg_write | output | 1 | Register file write enable |
| mem_to_reg | output | 1 | Register write data from memory |
| reg_dst | output | 1 | Destination register: 1 rd, 0 rt |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| iord | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_write | output | 1 | Instruction register load |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write when the zero flag is set |
| pc_source | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| pc_en | output | 1 | Effective PC load: pc_write, or pc_write_cond with alu_zero |

## Verification
Every control output is a function of the current micro-address, so it is valid within the same cycle. pc_en alone also depends on alu_zero in the same cycle. The opcode takes effect one cycle after it is sampled on the decode step. A reset edge shows the fetch word from the next cycle on. The driver changes the inputs at the falling edge that opens the second half of each instruction's first cycle. The monitor compares 4 ns later, one expected control word per cycle from the queue. The opcode is scrambled after decode to show that it is no longer used.

// File: rtl/useq_pkg.sv
// Shared types of the microcoded sequencer: the field encodings of one
// microinstruction, its packed layout and the micro-addresses of the
// entry points that the dispatch table and the control store agree on.
package useq_pkg;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_OR   = 2'b11
    } alu_f_e;

    typedef enum logic {
        SA_PC = 1'b0,
        SA_RS = 1'b1
    } srca_e;

    typedef enum logic [2:0] {
        SB_NONE  = 3'b000,
        SB_FOUR  = 3'b001,
        SB_RT    = 3'b010,
        SB_XSHL  = 3'b011,
        SB_XSIGN = 3'b100,
        SB_XZERO = 3'b101
    } srcb_e;

    typedef enum logic [1:0] {
        WB_NONE   = 2'b00,
        WB_RD_ALU = 2'b01,
        WB_RT_ALU = 2'b10,
        WB_RT_MEM = 2'b11
    } wb_e;

    typedef enum logic [1:0] {
        MA_NONE   = 2'b00,
        MA_RD_PC  = 2'b01,
        MA_RD_ALU = 2'b10,
        MA_WR_ALU = 2'b11
    } macc_e;

    typedef enum logic [1:0] {
        PW_NONE = 2'b00,
        PW_ALU  = 2'b01,
        PW_COND = 2'b10
    } pcw_e;

    typedef enum logic [1:0] {
        NX_FETCH = 2'b00,
        NX_DISP  = 2'b01,
        NX_STEP  = 2'b10
    } nxt_e;

    // 15-bit encoded microinstruction
    typedef struct packed {
        alu_f_e alu;
        srca_e  srca;
        srcb_e  srcb;
        wb_e    wb;
        macc_e  macc;
        logic   ir_ld;
        pcw_e   pcw;
        nxt_e   nxt;
    } uword_t;

    // entry points and steps of the microprogram
    localparam int UA_FETCH  = 0;
    localparam int UA_DECODE = 1;
    localparam int UA_BEQ    = 3;
    localparam int UA_ALU_EX = 4;
    localparam int UA_ALU_WB = 5;
    localparam int UA_ORI_EX = 6;
    localparam int UA_ORI_WB = 7;
    localparam int UA_LD_AD  = 8;
    localparam int UA_LD_MEM = 9;
    localparam int UA_LD_WB  = 10;
    localparam int UA_ST_AD  = 11;
    localparam int UA_ST_MEM = 12;

    // build one microinstruction from its fields
    function automatic uword_t mk_uword(alu_f_e a, srca_e sa, srcb_e sb, wb_e w,
                                        macc_e m, logic ir, pcw_e p, nxt_e n);
        uword_t u;
        u.alu   = a;
        u.srca  = sa;
        u.srcb  = sb;
        u.wb    = w;
        u.macc  = m;
        u.ir_ld = ir;
        u.pcw   = p;
        u.nxt   = n;
        return u;
    endfunction

endpackage

// File: rtl/useq_dispatch.sv
// Dispatch table: maps an instruction opcode to the micro-address of the
// first class-specific step. Unlisted opcodes map to the fetch word.
// Assumes OPC_W >= 6 and UPC_W >= 4.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int UPC_W = 4
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] target
);

    // opcode-to-entry lookup
    always_comb begin
        case (opcode)
            OPC_W'(6'b000000): target = UPC_W'(UA_ALU_EX);
            OPC_W'(6'b000100): target = UPC_W'(UA_BEQ);
            OPC_W'(6'b001101): target = UPC_W'(UA_ORI_EX);
            OPC_W'(6'b100011): target = UPC_W'(UA_LD_AD);
            OPC_W'(6'b101011): target = UPC_W'(UA_ST_AD);
            default:           target = UPC_W'(UA_FETCH);
        endcase
    end

endmodule

// File: rtl/useq_store.sv
// Control store: one encoded microinstruction per micro-address.
// Unused addresses hold an idle word that returns to fetch.
module useq_store
    import useq_pkg::*;
#(
    parameter int UPC_W = 4
) (
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);

    // microprogram contents
    always_comb begin
        case (addr)
            UPC_W'(UA_FETCH):  word = mk_uword(ALU_ADD,  SA_PC, SB_FOUR,  WB_NONE,   MA_RD_PC,  1'b1, PW_ALU,  NX_STEP);
            UPC_W'(UA_DECODE): word = mk_uword(ALU_ADD,  SA_PC, SB_XSHL,  WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_DISP);
            UPC_W'(UA_BEQ):    word = mk_uword(ALU_SUB,  SA_RS, SB_RT,    WB_NONE,   MA_NONE,   1'b0, PW_COND, NX_FETCH);
            UPC_W'(UA_ALU_EX): word = mk_uword(ALU_FUNC, SA_RS, SB_RT,    WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_STEP);
            UPC_W'(UA_ALU_WB): word = mk_uword(ALU_FUNC, SA_RS, SB_RT,    WB_RD_ALU, MA_NONE,   1'b0, PW_NONE, NX_FETCH);
            UPC_W'(UA_ORI_EX): word = mk_uword(ALU_OR,   SA_RS, SB_XZERO, WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_STEP);
            UPC_W'(UA_ORI_WB): word = mk_uword(ALU_OR,   SA_RS, SB_XZERO, WB_RT_ALU, MA_NONE,   1'b0, PW_NONE, NX_FETCH);
            UPC_W'(UA_LD_AD):  word = mk_uword(ALU_ADD,  SA_RS, SB_XSIGN, WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_STEP);
            UPC_W'(UA_LD_MEM): word = mk_uword(ALU_ADD,  SA_RS, SB_XSIGN, WB_NONE,   MA_RD_ALU, 1'b0, PW_NONE, NX_STEP);
            UPC_W'(UA_LD_WB):  word = mk_uword(ALU_ADD,  SA_RS, SB_XSIGN, WB_RT_MEM, MA_NONE,   1'b0, PW_NONE, NX_FETCH);
            UPC_W'(UA_ST_AD):  word = mk_uword(ALU_ADD,  SA_RS, SB_XSIGN, WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_STEP);
            UPC_W'(UA_ST_MEM): word = mk_uword(ALU_ADD,  SA_RS, SB_XSIGN, WB_NONE,   MA_WR_ALU, 1'b0, PW_NONE, NX_FETCH);
            default:           word = mk_uword(ALU_ADD,  SA_PC, SB_NONE,  WB_NONE,   MA_NONE,   1'b0, PW_NONE, NX_FETCH);
        endcase
    end

endmodule

// File: rtl/useq_decode.sv
// Field decoder: expands the narrow fields of a microinstruction into the
// individual datapath control lines and forms the effective PC load from
// the conditional write and the ALU zero flag. Purely combinational.
module useq_decode
    import useq_pkg::*;
(
    input  uword_t     word,
    input  logic       alu_zero,
    output logic [1:0] alu_op,
    output logic       alu_sel_a,
    output logic [1:0] alu_sel_b,
    output logic       ext_op,
    output logic       reg_write,
    output logic       mem_to_reg,
    output logic       reg_dst,
    output logic       mem_read,
    output logic       mem_write,
    output logic       iord,
    output logic       ir_write,
    output logic       pc_write,
    output logic       pc_write_cond,
    output logic       pc_source,
    output logic       pc_en
);

    // ALU function and first operand pass straight through
    always_comb begin
        alu_op    = word.alu;
        alu_sel_a = word.srca;
        ir_write  = word.ir_ld;
    end

    // second operand select and extension mode
    always_comb begin
        alu_sel_b = 2'b00;
        ext_op    = 1'b0;
        case (word.srcb)
            SB_FOUR:  alu_sel_b = 2'b00;
            SB_RT:    alu_sel_b = 2'b01;
            SB_XSHL:  begin alu_sel_b = 2'b10; ext_op = 1'b1; end
            SB_XSIGN: begin alu_sel_b = 2'b11; ext_op = 1'b1; end
            SB_XZERO: begin alu_sel_b = 2'b11; ext_op = 1'b0; end
            default:  begin alu_sel_b = 2'b00; ext_op = 1'b0; end
        endcase
    end

    // register write-back controls
    always_comb begin
        reg_write  = 1'b0;
        mem_to_reg = 1'b0;
        reg_dst    = 1'b0;
        case (word.wb)
            WB_RD_ALU: begin reg_write = 1'b1; reg_dst = 1'b1; end
            WB_RT_ALU: reg_write = 1'b1;
            WB_RT_MEM: begin reg_write = 1'b1; mem_to_reg = 1'b1; end
            default:   reg_write = 1'b0;
        endcase
    end

    // memory access controls
    always_comb begin
        mem_read  = 1'b0;
        mem_write = 1'b0;
        iord      = 1'b0;
        case (word.macc)
            MA_RD_PC:  mem_read = 1'b1;
            MA_RD_ALU: begin mem_read = 1'b1; iord = 1'b1; end
            MA_WR_ALU: begin mem_write = 1'b1; iord = 1'b1; end
            default:   mem_read = 1'b0;
        endcase
    end

    // PC update controls and effective load
    always_comb begin
        pc_write      = 1'b0;
        pc_write_cond = 1'b0;
        pc_source     = 1'b0;
        case (word.pcw)
            PW_ALU:  pc_write = 1'b1;
            PW_COND: begin pc_write_cond = 1'b1; pc_source = 1'b1; end
            default: pc_write = 1'b0;
        endcase
        pc_en = pc_write | (pc_write_cond & alu_zero);
    end

endmodule

// File: rtl/useq_ctrl.sv
// Microcoded control sequencer (top). Holds the micro-address register,
// chooses the next address from the sequencing field (fetch, dispatch,
// step) and drives the datapath controls from the decoded current word.
// Assumes the opcode is stable during the decode step.
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int UPC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic [1:0]       alu_op,
    output logic             alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic             ext_op,
    output logic             reg_write,
    output logic             mem_to_reg,
    output logic             reg_dst,
    output logic             mem_read,
    output logic             mem_write,
    output logic             iord,
    output logic             ir_write,
    output logic             pc_write,
    output logic             pc_write_cond,
    output logic             pc_source,
    output logic             pc_en
);

    logic [UPC_W-1:0] upc;
    logic [UPC_W-1:0] disp_tgt;
    uword_t           uw;

    useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
        .opcode (opcode),
        .target (disp_tgt)
    );

    useq_store #(.UPC_W(UPC_W)) u_store (
        .addr (upc),
        .word (uw)
    );

    useq_decode u_dec (
        .word          (uw),
        .alu_zero      (alu_zero),
        .alu_op        (alu_op),
        .alu_sel_a     (alu_sel_a),
        .alu_sel_b     (alu_sel_b),
        .ext_op        (ext_op),
        .reg_write     (reg_write),
        .mem_to_reg    (mem_to_reg),
        .reg_dst       (reg_dst),
        .mem_read      (mem_read),
        .mem_write     (mem_write),
        .iord          (iord),
        .ir_write      (ir_write),
        .pc_write      (pc_write),
        .pc_write_cond (pc_write_cond),
        .pc_source     (pc_source),
        .pc_en         (pc_en)
    );

    // micro-address register with next-address selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc <= '0;
        end else begin
            case (uw.nxt)
                NX_DISP: upc <= disp_tgt;
                NX_STEP: upc <= upc + UPC_W'(1);
                default: upc <= '0;
            endcase
        end
    end

    // reset lands on the fetch word
    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> (ir_write && mem_read && !iord && pc_write));

    // decode only leaves for a listed entry or back to fetch
    assert_dispatch_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UPC_W'(UA_DECODE)) |=>
        (upc inside {UPC_W'(UA_FETCH), UPC_W'(UA_BEQ), UPC_W'(UA_ALU_EX),
                     UPC_W'(UA_ORI_EX), UPC_W'(UA_LD_AD), UPC_W'(UA_ST_AD)}));

    // sequential step advances by one
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.nxt == NX_STEP) |=> (upc == UPC_W'($past(upc) + UPC_W'(1))));

    // an ending word returns to fetch
    assert_end_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.nxt == NX_FETCH) |=> (upc == '0));

    // memory is never read and written together
    assert_mem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read && mem_write));

    // conditional PC write is blocked without the zero flag
    assert_cond_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write_cond && !alu_zero && !pc_write) |-> !pc_en);

endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'b0;
    logic       alu_zero = 1'b0;
    logic [1:0] alu_op, alu_sel_b;
    logic alu_sel_a, ext_op, reg_write, mem_to_reg, reg_dst, mem_read, mem_write;
    logic iord, ir_write, pc_write, pc_write_cond, pc_source, pc_en;

    int n_checks = 0;
    int n_fails  = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];

    useq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .ext_op(ext_op),
        .reg_write(reg_write), .mem_to_reg(mem_to_reg), .reg_dst(reg_dst),
        .mem_read(mem_read), .mem_write(mem_write), .iord(iord), .ir_write(ir_write),
        .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_source(pc_source),
        .pc_en(pc_en)
    );

    always #5 clk = ~clk;

    // control word: alu_op, sel_a, sel_b, ext, rw, m2r, rdst, mrd, mwr, iord, irw, pcw, pcwc, pcs, pc_en
    function automatic logic [16:0] cw(logic [1:0] a, logic sa, logic [1:0] sb, logic ex,
                                       logic rw, logic m2r, logic rd, logic mr, logic mw,
                                       logic io, logic ir, logic pw, logic pwc, logic ps, logic pe);
        return {a, sa, sb, ex, rw, m2r, rd, mr, mw, io, ir, pw, pwc, ps, pe};
    endfunction

    function automatic logic [16:0] actual();
        return {alu_op, alu_sel_a, alu_sel_b, ext_op, reg_write, mem_to_reg, reg_dst,
                mem_read, mem_write, iord, ir_write, pc_write, pc_write_cond, pc_source, pc_en};
    endfunction

    localparam logic [16:0] E_FETCH = {2'b00,1'b0,2'b00,1'b0, 3'b000, 3'b100, 1'b1, 3'b100, 1'b1};
    localparam logic [16:0] E_DEC   = {2'b00,1'b0,2'b10,1'b1, 3'b000, 3'b000, 1'b0, 3'b000, 1'b0};

    task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic push(logic [16:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // driver: called at the falling edge inside an instruction's fetch cycle
    task automatic issue(logic [5:0] op, logic z);
        int len;
        opcode   = op;
        alu_zero = z;
        push(cw(2'b00,0,2'b00,0, 0,0,0, 1,0,0, 1, 1,0,0, 1), "R2 fetch");
        push(E_DEC, "R3 decode");
        case (op)
            6'b000000: begin
                len = 4;
                push(cw(2'b10,1,2'b01,0, 0,0,0, 0,0,0, 0, 0,0,0, 0), "R5 exec");
                push(cw(2'b10,1,2'b01,0, 1,0,1, 0,0,0, 0, 0,0,0, 0), "R5 writeback");
            end
            6'b001101: begin
                len = 4;
                push(cw(2'b11,1,2'b11,0, 0,0,0, 0,0,0, 0, 0,0,0, 0), "R6 exec");
                push(cw(2'b11,1,2'b11,0, 1,0,0, 0,0,0, 0, 0,0,0, 0), "R6 writeback");
            end
            6'b100011: begin
                len = 5;
                push(cw(2'b00,1,2'b11,1, 0,0,0, 0,0,0, 0, 0,0,0, 0), "R7 address");
                push(cw(2'b00,1,2'b11,1, 0,0,0, 1,0,1, 0, 0,0,0, 0), "R7 memread");
                push(cw(2'b00,1,2'b11,1, 1,1,0, 0,0,0, 0, 0,0,0, 0), "R7 writeback");
            end
            6'b101011: begin
                len = 4;
                push(cw(2'b00,1,2'b11,1, 0,0,0, 0,0,0, 0, 0,0,0, 0), "R8 address");
                push(cw(2'b00,1,2'b11,1, 0,0,0, 0,1,1, 0, 0,0,0, 0), "R8 memwrite");
            end
            6'b000100: begin
                len = 3;
                push(cw(2'b01,1,2'b01,0, 0,0,0, 0,0,0, 0, 0,1,1, z), "R9 branch");
            end
            default: len = 2; // R10 back to fetch
        endcase
        @(negedge clk);
        if (len > 2) begin
            @(negedge clk);
            opcode = ~op; // R3: opcode ignored after decode
            repeat (len - 2) @(negedge clk);
        end else begin
            @(negedge clk);
        end
    endtask

    // monitor: compare one expected word per cycle, late in the cycle
    always @(negedge clk) begin
        #4;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), actual(), exp_q.pop_front());
        end
    end

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #4 check("R1 reset", actual(), E_FETCH);
        @(negedge clk);
        rst_n = 1'b1;
        issue(6'b000000, 1'b0);
        issue(6'b001101, 1'b1);
        issue(6'b100011, 1'b0);
        issue(6'b101011, 1'b1);   // R9: zero high outside branch
        issue(6'b000100, 1'b1);   // R9 taken
        issue(6'b000100, 1'b0);   // R9 not taken
        issue(6'b111111, 1'b1);   // R10 unknown opcode
        issue(6'b000001, 1'b0);   // R10 near-miss opcode
        issue(6'b100011, 1'b1);
        issue(6'b000100, 1'b0);
        // R1: reset in the middle of a load
        opcode = 6'b100011;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #4 check("R1 midreset", actual(), E_FETCH);
        @(negedge clk);
        #4 check("R1 heldreset", actual(), E_FETCH);
        @(negedge clk);
        rst_n = 1'b1;
        issue(6'b101011, 1'b0);
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule